// File: doc/BRIEF.md
# Read Strobe Enable Calibration Sequencer

This block searches, one read strobe group at a time, for the gate timing at which the read strobe enable opens cleanly on the strobe preamble. Each trial works the same way. The block drives a fine enable delay code and a coarse read-latency (VFIFO) code. It asks the PHY for a short train of read commands on a valid/ready command stream, then waits for the PHY to report that the reads have completed. It then takes a per-bit pass vector from an external pattern checker. Per-bit deskew has not yet been done at this point, so any one passing bit is enough to accept a trial.

For one group, the fine delay is stepped upward from zero at the current latency code. When the fine code wraps past its top without a pass, the latency code goes up by one and the fine sweep runs again. The first passing setting is stored in a per-group result register and the block moves on to the next group, with both codes set back to zero. If a group runs out of latency codes, the block raises a fail flag that names the group and stops. A result port lets the integrator read any group's stored setting.

Top module: `dqsen_cal_seq`

## Requirements
- R1: While reset is low, and after it is released, `cmd_valid`, `busy`, `done` and `fail` are 0, and `dqsen_delay` and `vfifo_lat` are 0.
- R2: Each trial presents exactly BURST_LEN read commands on the command stream. A command is transferred on a cycle where `cmd_valid` and `cmd_ready` are both 1. While `cmd_ready` is 0, `cmd_valid` and `cmd_group` hold their values. No command is offered between the last transfer of a trial and that trial's `rd_done`.
- R3: In the cycle after every transferred command, `cmd_valid` is 0, leaving a single idle cycle between consecutive reads.
- R4: `dqsen_delay` and `vfifo_lat` do not change from the first command of a trial until the trial's `rd_done`. `pass_vec` is sampled only in a cycle where `rd_done` is 1 and a trial is waiting.
- R5: A trial passes when any bit of `pass_vec` is 1. A single set bit is enough.
- R6: The first trial of every group uses delay 0 and latency 0. After a failing trial below the top delay code, the next trial uses delay+1 at the same latency.
- R7: After a failing trial at the top delay code (all ones), the next trial uses delay 0 and latency+1.
- R8: On a passing trial, the current delay and latency are stored for the current group and can be read on `res_delay`/`res_lat` when `res_sel` selects that group. Groups are calibrated in order 0, 1, … NUM_GROUPS-1.
- R9: After the last group passes, `done` is 1, `fail` is 0, `busy` is 0 and no further commands are offered.
- R10: When a trial fails at the top delay code and latency code LAT_MAX, `fail` goes to 1, `fail_group` names the group, `done` is 1, and no later group is tried.
- R11: `start` is accepted only while the block is idle or done. An accepted `start` clears `done` and `fail` and begins again at group 0. A `start` that arrives while `busy` is 1 has no effect on the search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin calibration of all groups |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished (passed or failed) |
| fail | output | 1 | Sticky: a group exhausted all settings |
| fail_group | output | $clog2(NUM_GROUPS) | Group that failed |
| cmd_valid | output | 1 | Read command request |
| cmd_ready | input | 1 | PHY accepts the read command |
| cmd_group | output | $clog2(NUM_GROUPS) | Strobe group the read targets |
| rd_done | input | 1 | PHY reports the trial's reads are complete |
| pass_vec | input | DQ_BITS | Per-bit pattern-check result for the trial |
| dqsen_delay | output | DLY_BITS | Fine strobe-enable delay code |
| vfifo_lat | output | $clog2(LAT_MAX+1) | Coarse read-latency code |
| res_sel | input | $clog2(NUM_GROUPS) | Group selected on the result port |
| res_delay | output | DLY_BITS | Stored delay of the selected group |
| res_lat | output | $clog2(LAT_MAX+1) | Stored latency of the selected group |

## Verification
The hardest cases to reach are the corners of the search: a group that passes only at the very last setting (top delay, top latency), and a group that never passes. Both need the whole two-level sweep to run, and the wrap from the top delay code into the next latency must be seen on every step. The bench's PHY model answers each trial from a per-group pass window. One group's window is placed at the final setting, another group gets no window at all, and one window reports a single bit. Command acceptance is throttled by a fixed ready pattern so that back-pressure meets the idle-cycle rule. A stray `start` is also injected in the middle of a search.

// File: rtl/dqsen_pkg.sv
package dqsen_pkg;
  typedef enum logic [2:0] {
    S_IDLE,
    S_LAUNCH,
    S_BURST,
    S_WAIT,
    S_DONE
  } seq_state_t;
endpackage

// File: rtl/dqsen_burst.sv
module dqsen_burst #(
  parameter int BURST_LEN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  input  logic cmd_ready,
  output logic cmd_valid,
  output logic burst_sent
);
  localparam int CNT_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(BURST_LEN - 1);

  logic             active_q;
  logic             gap_q;
  logic [CNT_W-1:0] cnt_q;
  logic             xfer;

  assign cmd_valid  = active_q & ~gap_q;
  assign xfer       = cmd_valid & cmd_ready;
  assign burst_sent = xfer & (cnt_q == LAST_IDX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      gap_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (go) begin
      active_q <= 1'b1;
      gap_q    <= 1'b0;
      cnt_q    <= '0;
    end else if (xfer) begin
      if (cnt_q == LAST_IDX) begin
        active_q <= 1'b0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        gap_q <= 1'b1;
      end
    end else begin
      gap_q <= 1'b0;
    end
  end
endmodule

// File: rtl/dqsen_sweep.sv
module dqsen_sweep #(
  parameter int DLY_BITS = 3,
  parameter int LAT_MAX  = 3,
  localparam int LAT_W   = (LAT_MAX > 0) ? $clog2(LAT_MAX + 1) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clear,
  input  logic                step,
  output logic [DLY_BITS-1:0] delay,
  output logic [LAT_W-1:0]    lat,
  output logic                exhausted
);
  localparam logic [DLY_BITS-1:0] DLY_TOP = '1;
  localparam logic [LAT_W-1:0]    LAT_TOP = LAT_W'(LAT_MAX);

  assign exhausted = (delay == DLY_TOP) && (lat == LAT_TOP);

  always_ff @(posedge clk) begin
    if (!rst_n || clear) begin
      delay <= '0;
      lat   <= '0;
    end else if (step) begin
      if (delay == DLY_TOP) begin
        delay <= '0;
        lat   <= lat + 1'b1;
      end else begin
        delay <= delay + 1'b1;
      end
    end
  end
endmodule

// File: rtl/dqsen_result_file.sv
module dqsen_result_file #(
  parameter int NUM_GROUPS = 4,
  parameter int DLY_BITS   = 3,
  parameter int LAT_W      = 2,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [GRP_W-1:0]    wr_sel,
  input  logic [DLY_BITS-1:0] wr_delay,
  input  logic [LAT_W-1:0]    wr_lat,
  input  logic [GRP_W-1:0]    rd_sel,
  output logic [DLY_BITS-1:0] rd_delay,
  output logic [LAT_W-1:0]    rd_lat
);
  localparam logic [GRP_W:0] NG = NUM_GROUPS[GRP_W:0];

  logic [DLY_BITS-1:0] dly_q [NUM_GROUPS];
  logic [LAT_W-1:0]    lat_q [NUM_GROUPS];

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_entry
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        dly_q[g] <= '0;
        lat_q[g] <= '0;
      end else if (wr_en && (wr_sel == GRP_W'(g))) begin
        dly_q[g] <= wr_delay;
        lat_q[g] <= wr_lat;
      end
    end
  end

  always_comb begin
    rd_delay = '0;
    rd_lat   = '0;
    if ({1'b0, rd_sel} < NG) begin
      rd_delay = dly_q[rd_sel];
      rd_lat   = lat_q[rd_sel];
    end
  end
endmodule

// File: rtl/dqsen_cal_seq.sv
module dqsen_cal_seq
  import dqsen_pkg::*;
#(
  parameter int NUM_GROUPS = 4,
  parameter int DQ_BITS    = 8,
  parameter int DLY_BITS   = 3,
  parameter int LAT_MAX    = 3,
  parameter int BURST_LEN  = 4,
  localparam int GRP_W     = (NUM_GROUPS > 1) ? $clog2(NUM_GROUPS) : 1,
  localparam int LAT_W     = (LAT_MAX > 0) ? $clog2(LAT_MAX + 1) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                start,
  output logic                busy,
  output logic                done,
  output logic                fail,
  output logic [GRP_W-1:0]    fail_group,
  output logic                cmd_valid,
  input  logic                cmd_ready,
  output logic [GRP_W-1:0]    cmd_group,
  input  logic                rd_done,
  input  logic [DQ_BITS-1:0]  pass_vec,
  output logic [DLY_BITS-1:0] dqsen_delay,
  output logic [LAT_W-1:0]    vfifo_lat,
  input  logic [GRP_W-1:0]    res_sel,
  output logic [DLY_BITS-1:0] res_delay,
  output logic [LAT_W-1:0]    res_lat
);
  localparam logic [GRP_W-1:0] LAST_GRP = GRP_W'(NUM_GROUPS - 1);

  seq_state_t       state_q;
  logic [GRP_W-1:0] grp_q;
  logic             start_ok, take, hit, last_grp;
  logic             sw_clear, sw_step, exhausted, burst_sent, go;

  assign start_ok = start && (state_q == S_IDLE || state_q == S_DONE);
  assign take     = (state_q == S_WAIT) && rd_done;
  assign hit      = |pass_vec;
  assign last_grp = (grp_q == LAST_GRP);
  assign go       = (state_q == S_LAUNCH);
  assign sw_clear = start_ok || (take && hit && !last_grp);
  assign sw_step  = take && !hit && !exhausted;

  assign busy      = (state_q == S_LAUNCH) || (state_q == S_BURST) || (state_q == S_WAIT);
  assign done      = (state_q == S_DONE);
  assign cmd_group = grp_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      grp_q      <= '0;
      fail       <= 1'b0;
      fail_group <= '0;
    end else begin
      case (state_q)
        S_IDLE, S_DONE: begin
          if (start_ok) begin
            state_q    <= S_LAUNCH;
            grp_q      <= '0;
            fail       <= 1'b0;
            fail_group <= '0;
          end
        end
        S_LAUNCH: state_q <= S_BURST;
        S_BURST:  if (burst_sent) state_q <= S_WAIT;
        S_WAIT: begin
          if (take) begin
            if (hit) begin
              if (last_grp) begin
                state_q <= S_DONE;
              end else begin
                grp_q   <= grp_q + 1'b1;
                state_q <= S_LAUNCH;
              end
            end else if (exhausted) begin
              fail       <= 1'b1;
              fail_group <= grp_q;
              state_q    <= S_DONE;
            end else begin
              state_q <= S_LAUNCH;
            end
          end
        end
        default: state_q <= S_IDLE;
      endcase
    end
  end

  dqsen_burst #(.BURST_LEN(BURST_LEN)) u_burst (
    .clk(clk), .rst_n(rst_n), .go(go), .cmd_ready(cmd_ready),
    .cmd_valid(cmd_valid), .burst_sent(burst_sent)
  );

  dqsen_sweep #(.DLY_BITS(DLY_BITS), .LAT_MAX(LAT_MAX)) u_sweep (
    .clk(clk), .rst_n(rst_n), .clear(sw_clear), .step(sw_step),
    .delay(dqsen_delay), .lat(vfifo_lat), .exhausted(exhausted)
  );

  dqsen_result_file #(.NUM_GROUPS(NUM_GROUPS), .DLY_BITS(DLY_BITS), .LAT_W(LAT_W)) u_results (
    .clk(clk), .rst_n(rst_n), .wr_en(take && hit), .wr_sel(grp_q),
    .wr_delay(dqsen_delay), .wr_lat(vfifo_lat),
    .rd_sel(res_sel), .rd_delay(res_delay), .rd_lat(res_lat)
  );
endmodule

// File: rtl/dqsen_cal_chk.sv
module dqsen_cal_chk #(
  parameter int GW = 2,
  parameter int DW = 3,
  parameter int LW = 2
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [GW-1:0] cmd_group,
  input logic [DW-1:0] dqsen_delay,
  input logic [LW-1:0] vfifo_lat,
  input logic          busy,
  input logic          done,
  input logic          fail
);
  a_r3_idle_after_xfer: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_ready) |=> !cmd_valid);

  a_r2_hold_under_stall: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cmd_group)));

  a_r4_settings_steady: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |=> ($stable(dqsen_delay) && $stable(vfifo_lat)));

  a_r6_fresh_search: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> (dqsen_delay == '0 && vfifo_lat == '0));

  a_r8_group_order: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && cmd_group != $past(cmd_group))
      |-> ((cmd_group - $past(cmd_group)) == GW'(1)));

  a_r9_quiet_when_done: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!cmd_valid && !busy));

  a_r10_fail_ends_search: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> done);
endmodule

bind dqsen_cal_seq dqsen_cal_chk #(.GW(GRP_W), .DW(DLY_BITS), .LW(LAT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .cmd_group(cmd_group), .dqsen_delay(dqsen_delay), .vfifo_lat(vfifo_lat),
  .busy(busy), .done(done), .fail(fail)
);

// File: tb/tb_dqsen_cal_seq.sv
module tb_dqsen_cal_seq;
  localparam int NG = 4, DQ = 8, DB = 3, LM = 3, BL = 4;
  localparam int GW = 2, LW = 2, DMAX = 7;

  typedef struct { int g; int d; int l; } res_t;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, cmd_ready = 1'b0, rd_done = 1'b0;
  logic [DQ-1:0] pass_vec = '0;
  logic [GW-1:0] res_sel = '0;
  logic busy, done, fail, cmd_valid;
  logic [GW-1:0] fail_group, cmd_group;
  logic [DB-1:0] dqsen_delay, res_delay;
  logic [LW-1:0] vfifo_lat, res_lat;

  dqsen_cal_seq #(.NUM_GROUPS(NG), .DQ_BITS(DQ), .DLY_BITS(DB), .LAT_MAX(LM), .BURST_LEN(BL)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .busy(busy), .done(done), .fail(fail),
    .fail_group(fail_group), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_group(cmd_group), .rd_done(rd_done), .pass_vec(pass_vec),
    .dqsen_delay(dqsen_delay), .vfifo_lat(vfifo_lat), .res_sel(res_sel),
    .res_delay(res_delay), .res_lat(res_lat)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  int w_lat [NG], w_lo [NG], w_hi [NG];
  logic [DQ-1:0] w_bits [NG];
  int trials [NG], exp_trials [NG];
  res_t exp_q [$];
  bit exp_fail = 0, drained = 1, fresh = 0;
  int exp_fg = 0;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic logic [DQ-1:0] model(input int g, input int d, input int l);
    if (w_bits[g] != '0 && l == w_lat[g] && d >= w_lo[g] && d <= w_hi[g]) return w_bits[g];
    return '0;
  endfunction

  // PHY and pattern-checker model
  initial begin
    int acc_cnt, wait_n, tg, td, tl, pg, pd, pl;
    bit pend;
    acc_cnt = 0; wait_n = 0; pend = 0; tg = 0; td = 0; tl = 0; pg = 0; pd = 0; pl = 0;
    forever begin
      @(negedge clk);
      cyc++;
      rd_done = 1'b0;
      pass_vec = '0;
      if (!rst_n) begin
        cmd_ready = 1'b0; acc_cnt = 0; wait_n = 0; pend = 0;
        continue;
      end
      if (wait_n > 0) begin
        wait_n--;
        if (wait_n == 0) begin
          rd_done = 1'b1;
          pass_vec = model(tg, td, tl);
          acc_cnt = 0;
        end
      end
      if (pend) chk(!cmd_valid, "R3", "idle cycle after transfer", cmd_valid, 0);
      cmd_ready = ((cyc % 5) != 2);
      pend = cmd_valid && cmd_ready;
      if (pend) begin
        if (acc_cnt == 0 && wait_n == 0) begin
          tg = cmd_group; td = dqsen_delay; tl = vfifo_lat;
          trials[tg]++;
          if (fresh || tg != pg) begin
            if (!fresh) chk(tg == pg + 1, "R8", "group order", tg, pg + 1);
            chk(td == 0 && tl == 0, "R6", "first trial of group at zero", td * 16 + tl, 0);
          end else if (pd == DMAX) begin
            chk(td == 0 && tl == pl + 1, "R7", "delay wrap bumps latency", td * 16 + tl, pl + 1);
          end else begin
            chk(td == pd + 1 && tl == pl, "R6", "delay step", td * 16 + tl, (pd + 1) * 16 + pl);
          end
          fresh = 0; pg = tg; pd = td; pl = tl;
        end else begin
          chk(wait_n == 0 && acc_cnt < BL, "R2", "extra command in trial", acc_cnt + 1, BL);
          chk(dqsen_delay == td && vfifo_lat == tl && cmd_group == tg, "R4", "settings held in trial",
              dqsen_delay * 16 + vfifo_lat, td * 16 + tl);
        end
        acc_cnt++;
        if (acc_cnt == BL) wait_n = 3;
      end
    end
  end

  // Scoreboard monitor: pops expected results once the search ends
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && done && !drained) begin
        chk(fail == exp_fail, exp_fail ? "R10" : "R9", "fail flag", fail, exp_fail);
        if (exp_fail) chk(fail_group == exp_fg, "R10", "fail group", fail_group, exp_fg);
        chk(!busy && !cmd_valid, "R9", "idle when done", busy + 2 * cmd_valid, 0);
        while (exp_q.size() > 0) begin
          res_t it;
          it = exp_q.pop_front();
          res_sel = it.g[GW-1:0];
          #1;
          chk(res_delay == it.d, "R8", $sformatf("group %0d stored delay", it.g), res_delay, it.d);
          chk(res_lat == it.l, "R8", $sformatf("group %0d stored latency", it.g), res_lat, it.l);
        end
        for (int g = 0; g < NG; g++) begin
          chk(trials[g] == exp_trials[g], exp_fail ? "R10" : "R7",
              $sformatf("group %0d trial count", g), trials[g], exp_trials[g]);
          trials[g] = 0;
        end
        drained = 1;
      end
    end
  end

  task automatic set_win(input int g, input int l, input int lo, input int hi, input logic [DQ-1:0] b);
    w_lat[g] = l; w_lo[g] = lo; w_hi[g] = hi; w_bits[g] = b;
  endtask

  task automatic run_case(input int glitch_at);
    bit stop;
    stop = 0; exp_fail = 0;
    for (int g = 0; g < NG; g++) begin
      if (stop) exp_trials[g] = 0;
      else if (w_bits[g] != '0) begin
        res_t it;
        it.g = g; it.d = w_lo[g]; it.l = w_lat[g];
        exp_q.push_back(it);
        exp_trials[g] = w_lat[g] * (DMAX + 1) + w_lo[g] + 1;
      end else begin
        exp_trials[g] = (LM + 1) * (DMAX + 1);
        exp_fail = 1; exp_fg = g; stop = 1;
      end
    end
    fresh = 1;
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0; drained = 0;
    chk(busy && !done && !fail, "R11", "start accepted", busy, 1);
    if (glitch_at > 0) begin
      repeat (glitch_at) @(negedge clk);
      chk(busy, "R11", "busy before stray start", busy, 1);
      start = 1'b1;
      @(negedge clk); start = 1'b0;
    end
    while (!drained) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    for (int g = 0; g < NG; g++) begin trials[g] = 0; set_win(g, 0, 0, 0, '0); end
    repeat (3) @(negedge clk);
    chk(!cmd_valid && !busy && !done && !fail, "R1", "outputs in reset",
        cmd_valid + busy + done + fail, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!cmd_valid && !busy && !done && !fail, "R1", "outputs after reset",
        cmd_valid + busy + done + fail, 0);
    chk(dqsen_delay == 0 && vfifo_lat == 0, "R1", "codes after reset", dqsen_delay + vfifo_lat, 0);

    // Case A: group 1 never passes -> fail names group 1 (R10)
    set_win(0, 0, 1, 4, 8'h0F);
    set_win(1, 0, 0, 0, 8'h00);
    set_win(2, 1, 2, 3, 8'hFF);
    set_win(3, 0, 0, 0, 8'hFF);
    run_case(0);

    // Case B: all pass; single-bit pass (R5) and last-setting corner (R7)
    set_win(0, 0, 0, 2, 8'hFF);
    set_win(1, 1, 5, 6, 8'h10);
    set_win(2, 3, 7, 7, 8'h80);
    set_win(3, 2, 3, 3, 8'h01);
    run_case(0);
    chk(!fail, "R11", "restart cleared fail", fail, 0);

    // Case C: stray start during search is ignored (R11)
    set_win(0, 1, 0, 7, 8'h40);
    set_win(1, 0, 6, 7, 8'h02);
    set_win(2, 2, 1, 1, 8'h20);
    set_win(3, 0, 7, 7, 8'h04);
    run_case(40);

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule